// File: doc/BRIEF.md
# Frame-Synchronous Exposure Parameter Retimer

This block sits between the host register interface and the pixel array timing of an image sensor. The host writes four exposure parameters: a coarse line count, a fine pixel count, an analogue gain code and a clock divide code. Each write lands in a shadow copy. The copy the array uses, called the active copy, only changes at a frame boundary. A half-updated parameter set therefore never reaches the array in the middle of a frame.

Gain reaches the active set one transfer boundary after the other three parameters. This lines the gain change up with the frame whose exposure it belongs to. While the host drives the page-busy input, which means a multi-byte write to the exposure registers is still under way, every transfer at a frame start is held back. Coarse and fine values are clipped when they are written, against the frame and line lengths the timing generator supplies. A free-running frame counter and an odd/even frame flag come out alongside the parameters.

Top module: `exp_retimer`

## Requirements
- R1: After reset the active and shadow values are coarse 522, fine 0, gain 0 and divider 0. All pending flags, the frame counter and the odd flag are 0.
- R2: A write with `wr_sel_i` = 0 (fine), 1 (coarse), 2 (gain) or 3 (divider) updates that shadow on the next clock. `rd_data_o` always shows the shadow chosen by `rd_sel_i` (same encoding, zero-extended). Active values do not move without a frame start.
- R3: Coarse, fine and divider move from shadow to active at the first frame start after the write where `page_busy_i` is low. The matching pending flag clears at that same edge.
- R4: Gain moves from shadow to active at the second such transfer boundary after its write. Its pending flag stays set until the gain is active.
- R5: The pending flags sit at fixed bit positions: bit 0 fine, bit 1 coarse, bit 2 gain, bit 3 divider. A write sets its bit on the next clock.
- R6: A frame start with `page_busy_i` high transfers nothing and leaves every pending flag as it was. The frame counter and odd flag still advance.
- R7: If a write and a transfer happen in the same cycle, the transfer uses the shadow value held before the write. The new value stays pending and moves at the following transfer.
- R8: A coarse write is clipped to at most `frame_len_i` − 2, or to 0 when `frame_len_i` < 2.
- R9: A fine write is clipped to at most `line_len_i` and then to at least 11. If `line_len_i` < 11, the result is 11.
- R10: The 8-bit frame counter adds one on every frame start and wraps from 255 to 0. The odd flag toggles on every frame start.
- R11: Gain and divider writes keep only `wr_data_i[3:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Parameter write strobe |
| wr_sel_i | input | 2 | Write target: 0 fine, 1 coarse, 2 gain, 3 divider |
| wr_data_i | input | 10 | Write data |
| page_busy_i | input | 1 | Multi-byte exposure-page write in progress |
| frame_start_i | input | 1 | One-cycle frame boundary pulse |
| frame_len_i | input | 10 | Lines per frame, used to clip coarse |
| line_len_i | input | 10 | Pixels per line, used to clip fine |
| rd_sel_i | input | 2 | Shadow readback select, same encoding as wr_sel_i |
| rd_data_o | output | 10 | Selected shadow value, zero-extended |
| act_fine_o | output | 10 | Active fine exposure |
| act_coarse_o | output | 10 | Active coarse exposure |
| act_gain_o | output | 4 | Active gain |
| act_div_o | output | 4 | Active clock divider |
| pending_o | output | 4 | Per-parameter pending flags |
| frame_cnt_o | output | 8 | Frame counter |
| odd_frame_o | output | 1 | Odd/even frame flag |

## Verification
The hardest state to reach is a gain value already staged for the next boundary while a newer gain write sits pending behind it. A busy frame start must hold both of them in place, and a write in the same cycle as a transfer must not be swallowed. Directed sequences build each of these cases: a gain write, one transfer, a second gain write, then a busy boundary and a colliding write. A long random phase follows with frequent writes, frame starts and busy periods. A cycle-level reference model compares every output on every clock during both phases.

// File: rtl/exp_pkg.sv
package exp_pkg;
  typedef enum logic [1:0] {
    SEL_FINE   = 2'd0,
    SEL_COARSE = 2'd1,
    SEL_GAIN   = 2'd2,
    SEL_DIV    = 2'd3
  } par_sel_e;

  localparam int unsigned NUM_PAR = 4;
endpackage

// File: rtl/exp_clip.sv
module exp_clip import exp_pkg::*; #(
  parameter int unsigned PW       = 10,
  parameter int unsigned FINE_MIN = 11
) (
  input  par_sel_e        sel_i,
  input  logic [PW-1:0]   data_i,
  input  logic [PW-1:0]   frame_len_i,
  input  logic [PW-1:0]   line_len_i,
  output logic [PW-1:0]   val_o
);
  localparam logic [PW-1:0] FMIN = PW'(FINE_MIN);
  localparam logic [PW-1:0] TWO  = PW'(2);

  logic [PW-1:0] coarse_hi, coarse_v, fine_cap, fine_v;

  always_comb begin
    coarse_hi = (frame_len_i >= TWO) ? frame_len_i - TWO : '0;
    coarse_v  = (data_i > coarse_hi) ? coarse_hi : data_i;
    fine_cap  = (data_i > line_len_i) ? line_len_i : data_i;
    fine_v    = (fine_cap < FMIN) ? FMIN : fine_cap;
  end

  always_comb begin
    unique case (sel_i)
      SEL_FINE:   val_o = fine_v;
      SEL_COARSE: val_o = coarse_v;
      default:    val_o = data_i;
    endcase
  end
endmodule

// File: rtl/exp_slot.sv
module exp_slot #(
  parameter int unsigned   W       = 10,
  parameter logic [W-1:0]  RST_VAL = '0,
  parameter bit            LAG     = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [W-1:0]  data_i,
  input  logic          xfer_i,
  output logic [W-1:0]  shadow_o,
  output logic [W-1:0]  active_o,
  output logic          pending_o
);
  logic [W-1:0] shadow_q, active_q;
  logic         pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   shadow_q <= RST_VAL;
    else if (wr_i) shadow_q <= data_i;
  end

  // write wins over a same-cycle transfer: new value stays pending
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (wr_i)   pend_q <= 1'b1;
    else if (xfer_i) pend_q <= 1'b0;
  end

  assign shadow_o = shadow_q;
  assign active_o = active_q;

  generate
    if (LAG) begin : g_lag
      logic [W-1:0] stage_q;
      logic         stage_v_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          active_q  <= RST_VAL;
          stage_q   <= RST_VAL;
          stage_v_q <= 1'b0;
        end else if (xfer_i) begin
          if (stage_v_q) active_q <= stage_q;
          if (pend_q)    stage_q  <= shadow_q;
          stage_v_q <= pend_q;
        end
      end

      assign pending_o = pend_q | stage_v_q;

      // R4
      lag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        xfer_i && pend_q |=> pending_o);
      // R4
      lag_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        xfer_i && !pend_q && !wr_i |=> !pending_o);
    end else begin : g_direct
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)               active_q <= RST_VAL;
        else if (xfer_i && pend_q) active_q <= shadow_q;
      end

      assign pending_o = pend_q;

      // R3
      direct_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        xfer_i && !wr_i |=> !pending_o);
    end
  endgenerate

  // R5
  wr_sets_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> pending_o);
  // R2
  active_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_i |=> $stable(active_o));
endmodule

// File: rtl/exp_frame_ctr.sv
module exp_frame_ctr #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_i,
  output logic [CW-1:0] cnt_o,
  output logic          odd_o
);
  logic [CW-1:0] cnt_q;
  logic          odd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      odd_q <= 1'b0;
    end else if (frame_i) begin
      cnt_q <= cnt_q + 1'b1;
      odd_q <= ~odd_q;
    end
  end

  assign cnt_o = cnt_q;
  assign odd_o = odd_q;

  // R10
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> cnt_o == CW'($past(cnt_o) + 1'b1));
  // R10
  odd_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> odd_o != $past(odd_o));
  // R10
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(cnt_o) && $stable(odd_o));
endmodule

// File: rtl/exp_retimer.sv
module exp_retimer import exp_pkg::*; #(
  parameter int unsigned PW         = 10,
  parameter int unsigned GW         = 4,
  parameter int unsigned CW         = 8,
  parameter int unsigned COARSE_RST = 522,
  parameter int unsigned FINE_MIN   = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [PW-1:0] wr_data_i,
  input  logic          page_busy_i,
  input  logic          frame_start_i,
  input  logic [PW-1:0] frame_len_i,
  input  logic [PW-1:0] line_len_i,
  input  logic [1:0]    rd_sel_i,
  output logic [PW-1:0] rd_data_o,
  output logic [PW-1:0] act_fine_o,
  output logic [PW-1:0] act_coarse_o,
  output logic [GW-1:0] act_gain_o,
  output logic [GW-1:0] act_div_o,
  output logic [NUM_PAR-1:0] pending_o,
  output logic [CW-1:0] frame_cnt_o,
  output logic          odd_frame_o
);
  localparam logic [PW-1:0] COARSE_DEF = PW'(COARSE_RST);
  localparam logic [PW-1:0] FMIN       = PW'(FINE_MIN);

  par_sel_e      wsel;
  logic [PW-1:0] clip_val;
  logic [NUM_PAR-1:0] wr_hit;
  logic          xfer;
  logic [PW-1:0] sh_fine, sh_coarse;
  logic [GW-1:0] sh_gain, sh_div;

  assign wsel = par_sel_e'(wr_sel_i);
  assign xfer = frame_start_i & ~page_busy_i;

  always_comb begin
    wr_hit = '0;
    wr_hit[wr_sel_i] = wr_en_i;
  end

  exp_clip #(.PW(PW), .FINE_MIN(FINE_MIN)) u_clip (
    .sel_i       (wsel),
    .data_i      (wr_data_i),
    .frame_len_i (frame_len_i),
    .line_len_i  (line_len_i),
    .val_o       (clip_val)
  );

  exp_slot #(.W(PW), .RST_VAL('0), .LAG(1'b0)) u_fine (
    .clk_i, .rst_ni,
    .wr_i      (wr_hit[SEL_FINE]),
    .data_i    (clip_val),
    .xfer_i    (xfer),
    .shadow_o  (sh_fine),
    .active_o  (act_fine_o),
    .pending_o (pending_o[SEL_FINE])
  );

  exp_slot #(.W(PW), .RST_VAL(COARSE_DEF), .LAG(1'b0)) u_coarse (
    .clk_i, .rst_ni,
    .wr_i      (wr_hit[SEL_COARSE]),
    .data_i    (clip_val),
    .xfer_i    (xfer),
    .shadow_o  (sh_coarse),
    .active_o  (act_coarse_o),
    .pending_o (pending_o[SEL_COARSE])
  );

  // gain lags one transfer so it meets the frame its exposure produced
  exp_slot #(.W(GW), .RST_VAL('0), .LAG(1'b1)) u_gain (
    .clk_i, .rst_ni,
    .wr_i      (wr_hit[SEL_GAIN]),
    .data_i    (clip_val[GW-1:0]),
    .xfer_i    (xfer),
    .shadow_o  (sh_gain),
    .active_o  (act_gain_o),
    .pending_o (pending_o[SEL_GAIN])
  );

  exp_slot #(.W(GW), .RST_VAL('0), .LAG(1'b0)) u_div (
    .clk_i, .rst_ni,
    .wr_i      (wr_hit[SEL_DIV]),
    .data_i    (clip_val[GW-1:0]),
    .xfer_i    (xfer),
    .shadow_o  (sh_div),
    .active_o  (act_div_o),
    .pending_o (pending_o[SEL_DIV])
  );

  exp_frame_ctr #(.CW(CW)) u_ctr (
    .clk_i, .rst_ni,
    .frame_i (frame_start_i),
    .cnt_o   (frame_cnt_o),
    .odd_o   (odd_frame_o)
  );

  always_comb begin
    unique case (par_sel_e'(rd_sel_i))
      SEL_FINE:   rd_data_o = sh_fine;
      SEL_COARSE: rd_data_o = sh_coarse;
      SEL_GAIN:   rd_data_o = {{(PW-GW){1'b0}}, sh_gain};
      default:    rd_data_o = {{(PW-GW){1'b0}}, sh_div};
    endcase
  end

  // R9
  fine_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_sel_i == SEL_FINE |=> sh_fine >= FMIN);
  // R8
  coarse_ceil_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_sel_i == SEL_COARSE && frame_len_i >= PW'(2)
    |=> sh_coarse <= $past(frame_len_i) - PW'(2));
  // R6
  busy_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i && page_busy_i && !wr_en_i |=> $stable(pending_o));
endmodule

// File: tb/tb_exp_retimer.sv
module tb_exp_retimer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, page_busy = 1'b0, frame_start = 1'b0;
  logic [1:0] wr_sel = '0, rd_sel = '0;
  logic [9:0] wr_data = '0, frame_len = 10'd524, line_len = 10'd762;
  logic [9:0] rd_data, act_fine, act_coarse;
  logic [3:0] act_gain, act_div, pending;
  logic [7:0] frame_cnt;
  logic       odd_frame;

  always #4 clk = ~clk;

  exp_retimer dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .page_busy_i(page_busy), .frame_start_i(frame_start),
    .frame_len_i(frame_len), .line_len_i(line_len), .rd_sel_i(rd_sel),
    .rd_data_o(rd_data), .act_fine_o(act_fine), .act_coarse_o(act_coarse),
    .act_gain_o(act_gain), .act_div_o(act_div), .pending_o(pending),
    .frame_cnt_o(frame_cnt), .odd_frame_o(odd_frame)
  );

  int checks = 0, errors = 0, rdc = 0;
  string tag = "R1";

  // reference model: index 0 fine, 1 coarse, 2 gain, 3 divider
  int sh[4], act[4];
  bit pend[4];
  int gq[$];   // gain values captured and waiting for the next boundary
  int cnt;
  bit odd;

  function automatic void model_reset();
    sh  = '{0, 522, 0, 0};
    act = '{0, 522, 0, 0};
    pend = '{0, 0, 0, 0};
    gq.delete();
    cnt = 0; odd = 0;
  endfunction

  function automatic int clip(int sel, int d, int fl, int ll);
    int v;
    if (sel == 1) begin
      v = (fl >= 2) ? fl - 2 : 0;
      return (d > v) ? v : d;
    end
    if (sel == 0) begin
      v = (d > ll) ? ll : d;
      return (v < 11) ? 11 : v;
    end
    return d % 16;
  endfunction

  function automatic void model_step(bit we, int sel, int d, bit busy, bit fs);
    if (fs && !busy) begin
      if (gq.size() > 0) act[2] = gq.pop_front();
      if (pend[2]) begin gq.push_back(sh[2]); pend[2] = 0; end
      foreach (pend[i]) if (i != 2 && pend[i]) begin act[i] = sh[i]; pend[i] = 0; end
    end
    if (we) begin sh[sel] = clip(sel, d, int'(frame_len), int'(line_len)); pend[sel] = 1; end
    if (fs) begin cnt = (cnt + 1) % 256; odd = !odd; end
  endfunction

  task automatic chk(string name, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, name, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    int pv;
    pv = (pend[0] ? 1 : 0) + (pend[1] ? 2 : 0) + ((pend[2] || gq.size() > 0) ? 4 : 0) + (pend[3] ? 8 : 0);
    chk("act_fine", int'(act_fine), act[0]);
    chk("act_coarse", int'(act_coarse), act[1]);
    chk("act_gain", int'(act_gain), act[2]);
    chk("act_div", int'(act_div), act[3]);
    chk("pending", int'(pending), pv);
    chk("frame_cnt", int'(frame_cnt), cnt);
    chk("odd_frame", int'(odd_frame), int'(odd));
    chk("rd_data", int'(rd_data), sh[rd_sel]);
  endtask

  // called at a negedge; returns at the next negedge after comparing
  task automatic step(bit we, int sel, int d, bit busy, bit fs);
    wr_en = we; wr_sel = sel[1:0]; wr_data = d[9:0];
    page_busy = busy; frame_start = fs; rd_sel = rdc[1:0]; rdc++;
    @(posedge clk);
    model_step(we, sel, d, busy, fs);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 8);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    compare_all();            // R1 reset state
    rst_n = 1'b1;
    idle(2);

    tag = "R2";
    step(1, 0, 100, 0, 0);
    step(1, 1, 300, 0, 0);
    idle(4);
    tag = "R3";
    step(0, 0, 0, 0, 1);
    idle(2);
    tag = "R4";
    step(1, 2, 5, 0, 0);
    step(0, 0, 0, 0, 1);
    idle(2);
    step(1, 2, 9, 0, 0);
    step(0, 0, 0, 0, 1);
    idle(1);
    step(0, 0, 0, 0, 1);
    idle(1);
    tag = "R11";
    step(1, 3, 10'h3F7, 0, 0);
    step(1, 2, 10'h2A, 0, 0);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1);
    tag = "R5";
    step(1, 3, 2, 0, 0);
    step(1, 0, 50, 0, 0);
    idle(2);
    tag = "R6";
    step(1, 1, 400, 0, 0);
    step(1, 2, 3, 0, 0);
    step(0, 0, 0, 1, 1);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 1);
    step(1, 2, 6, 0, 0);
    step(0, 0, 0, 1, 1);
    idle(1);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1);
    tag = "R7";
    step(1, 1, 200, 0, 0);
    step(1, 1, 250, 0, 1);
    idle(1);
    step(1, 2, 7, 0, 1);
    step(1, 2, 8, 0, 1);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1);
    tag = "R8";
    frame_len = 10'd100;
    step(1, 1, 500, 0, 0);
    step(1, 1, 97, 0, 0);
    frame_len = 10'd1;
    step(1, 1, 20, 0, 0);
    frame_len = 10'd524;
    step(1, 1, 1023, 0, 1);
    tag = "R9";
    step(1, 0, 5, 0, 0);
    step(1, 0, 900, 0, 0);
    line_len = 10'd8;
    step(1, 0, 600, 0, 0);
    line_len = 10'd762;
    step(1, 0, 11, 0, 1);
    tag = "R10";
    for (int i = 0; i < 260; i++) step(0, 0, 0, 0, 1);

    tag = "R3";
    for (int i = 0; i < 2000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 5) frame_len = 10'($urandom_range(0, 1023));
      if (r > 94) line_len = 10'($urandom_range(0, 1023));
      step($urandom_range(0, 2) == 0, $urandom_range(0, 3), $urandom_range(0, 1023),
           $urandom_range(0, 5) == 0, $urandom_range(0, 4) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule